// File: doc/BRIEF.md
# Interleaved Section Output Multiplexer

This block sits at the output of a converter built from several successive-approximation sections that run in parallel and take turns sampling the input. Each section presents an 11-bit result together with a one-cycle transfer strobe when its conversion is complete. The block accepts the results in strict round-robin order, starting at section 0. It turns each result into a 10-bit straight-binary word plus an overrange flag, and registers both on the rising clock edge.

A result at or above full scale sets the overrange flag and clamps the data word to all ones. A one-cycle data-valid pulse marks every new word, so data-valid toggles on every clock when the sections deliver a word every other clock. An active-low enable puts the data and overrange outputs into the high-impedance state. A companion flag reports whether the outputs are being driven.

Top module: `interleave_out_mux`

## Requirements
- R1: After reset, the data output and the overrange output are 0, data-valid is 0, and section 0 is the next section to be accepted.
- R2: A section result below 1024 (2^DATA_W) appears unchanged on the data output, with overrange 0, right after the rising edge at which its strobe was sampled.
- R3: A section result of 1024 or above sets overrange to 1 at that same edge and forces all ten data bits to 1.
- R4: Results are accepted in section order 0, 1, ..., 7, then back to 0. The section index is the position of the section's strobe bit and of its 11-bit field in the flattened result bus (section k occupies bits 11k+10 down to 11k).
- R5: A strobe from any section other than the one expected next is ignored. Data, overrange and data-valid do not change, and the expected section does not advance.
- R6: Data-valid is 1 for exactly the one cycle after each accepted word. When words are accepted every second clock, it alternates 1 and 0 on successive clocks.
- R7: Between accepted words, the data and overrange outputs hold their last value.
- R8: While the active-low enable is 1, the data and overrange outputs are high impedance and the output-enable flag is 0. While the enable is 0, the outputs are driven and the flag is 1. Data-valid is always driven.
- R9: The enable has no effect on the registered word. A word accepted while the outputs were in high impedance appears once the enable returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| secResult | input | 88 | Flattened 11-bit results of the eight sections, section 0 in the low bits |
| secXfer | input | 8 | Per-section transfer strobes, bit k for section k |
| enN | input | 1 | Active-low output enable for data and overrange |
| dataOut | output | 10 | Straight-binary output word, tri-stated when disabled |
| overOut | output | 1 | Overrange flag, tri-stated when disabled |
| dataValid | output | 1 | One-cycle pulse after each accepted word |
| outEnable | output | 1 | High while data and overrange are being driven |

## Verification
The bench builds the block with its default eight sections and 10-bit words. With these values the overrange boundary sits at exactly 1023 and 1024 on an 11-bit result, and a single eight-step round exercises the wrap of the section pointer from 7 back to 0. Out-of-turn strobes, back-to-back and alternate-cycle transfers, and words accepted while the outputs are in high impedance are all reachable with this configuration.

// File: rtl/interleave_out_mux_pkg.sv
package interleave_out_mux_pkg;
  localparam int MAX_SEL_W = 8;

  typedef struct packed {
    logic                 load;
    logic [MAX_SEL_W-1:0] sel;
  } muxStrobe_t;
endpackage

// File: rtl/interleave_out_mux_ctrl.sv
module interleave_out_mux_ctrl
  import interleave_out_mux_pkg::*;
#(
  parameter int NUM_SECT = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SECT-1:0] secXfer,
  output muxStrobe_t          strobe
);
  localparam int SEL_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_SECT - 1);

  logic [SEL_W-1:0] nextSel;
  logic             take;

  // only the section whose turn it is may transfer
  assign take = secXfer[nextSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextSel <= '0;
    end else if (take) begin
      nextSel <= (nextSel == LAST_SEL) ? '0 : nextSel + 1'b1;
    end
  end

  always_comb begin
    strobe      = '0;
    strobe.load = take;
    strobe.sel  = MAX_SEL_W'(nextSel);
  end

  // R4: pointer steps by one section per accepted word, wrapping at the end
  p_rr_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
    take |=> (nextSel == (($past(nextSel) == LAST_SEL) ? '0 : $past(nextSel) + 1'b1)));

  // R5: without an accepted transfer the pointer stays put
  p_no_skip_r5: assert property (@(posedge clk) disable iff (!rstN)
    !take |=> $stable(nextSel));
endmodule

// File: rtl/interleave_out_mux_dp.sv
module interleave_out_mux_dp
  import interleave_out_mux_pkg::*;
#(
  parameter int NUM_SECT = 8,
  parameter int DATA_W   = 10
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_SECT*(DATA_W+1)-1:0] secResult,
  input  muxStrobe_t                     strobe,
  output logic [DATA_W-1:0]              dataReg,
  output logic                           overReg,
  output logic                           validReg
);
  localparam int RES_W = DATA_W + 1;

  logic [RES_W-1:0] picked [NUM_SECT];
  logic [RES_W-1:0] chosen;
  logic             isOver;

  for (genvar k = 0; k < NUM_SECT; k++) begin : g_unpack
    assign picked[k] = secResult[k*RES_W +: RES_W];
  end

  assign chosen = picked[strobe.sel[$clog2(NUM_SECT > 1 ? NUM_SECT : 2)-1:0]];
  assign isOver = chosen[DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      overReg  <= 1'b0;
      validReg <= 1'b0;
    end else begin
      validReg <= strobe.load;
      if (strobe.load) begin
        overReg <= isOver;
        dataReg <= isOver ? '1 : chosen[DATA_W-1:0];
      end
    end
  end

  // R3: an overrange word always carries an all-ones data field
  p_clamp_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    overReg |-> (&dataReg));

  // R6: data-valid follows an accepted transfer by exactly one edge
  p_valid_after_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> validReg);

  // R7: registered word holds when nothing is accepted
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(dataReg) && $stable(overReg) && !validReg));
endmodule

// File: rtl/interleave_out_mux.sv
module interleave_out_mux
  import interleave_out_mux_pkg::*;
#(
  parameter int NUM_SECT = 8,
  parameter int DATA_W   = 10
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_SECT*(DATA_W+1)-1:0] secResult,
  input  logic [NUM_SECT-1:0]            secXfer,
  input  logic                           enN,
  output logic [DATA_W-1:0]              dataOut,
  output logic                           overOut,
  output logic                           dataValid,
  output logic                           outEnable
);
  muxStrobe_t          strobe;
  logic [DATA_W-1:0]   dataReg;
  logic                overReg;

  interleave_out_mux_ctrl #(.NUM_SECT(NUM_SECT)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .secXfer (secXfer),
    .strobe  (strobe)
  );

  interleave_out_mux_dp #(.NUM_SECT(NUM_SECT), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .secResult (secResult),
    .strobe    (strobe),
    .dataReg   (dataReg),
    .overReg   (overReg),
    .validReg  (dataValid)
  );

  assign outEnable = ~enN;
  assign dataOut   = outEnable ? dataReg : 'z;
  assign overOut   = outEnable ? overReg : 1'bz;

  // R2: an in-range result reaches the word register unchanged
  p_pass_through_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !secResult[strobe.sel*(DATA_W+1) + DATA_W])
      |=> (!overReg && dataReg == $past(secResult[strobe.sel*(DATA_W+1) +: DATA_W])));
endmodule

// File: tb/interleave_out_mux_test.sv
module interleave_out_mux_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int DW = 10;
  localparam int RW = DW + 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NS*RW-1:0]  secResult = '0;
  logic [NS-1:0]     secXfer = '0;
  logic              enN = 1'b0;
  wire  [DW-1:0]     dataOut;
  wire               overOut;
  logic              dataValid;
  logic              outEnable;

  int checks = 0;
  int fails  = 0;
  int expPtr = 0;
  logic [RW-1:0] expQ [$];
  logic [DW-1:0] lastData = '0;
  logic          lastOver = 1'b0;
  bit            monOn = 1'b0;
  bit            done  = 1'b0;

  interleave_out_mux #(.NUM_SECT(NS), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .secResult(secResult), .secXfer(secXfer),
    .enN(enN), .dataOut(dataOut), .overOut(overOut),
    .dataValid(dataValid), .outEnable(outEnable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected formatted word as {over, data}
  function automatic logic [RW-1:0] fmt(input logic [RW-1:0] r);
    if (r >= RW'(1 << DW)) return {1'b1, {DW{1'b1}}};
    return {1'b0, r[DW-1:0]};
  endfunction

  // drive one section's strobe for one cycle, then idle cycles
  task automatic send(input int sect, input logic [RW-1:0] val, input int gap);
    @(negedge clk);
    secResult[sect*RW +: RW] = val;
    secXfer = '0;
    secXfer[sect] = 1'b1;
    if (sect == expPtr) begin
      expQ.push_back(fmt(val));
      expPtr = (expPtr + 1) % NS;
    end
    @(negedge clk);
    secXfer = '0;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  // scoreboard monitor: compares every valid word with the queue head
  initial begin
    forever begin
      @(negedge clk);
      if (monOn && dataValid) begin
        if (expQ.size() == 0) begin
          check("R5 unexpected valid", 32'(dataValid), 32'd0);
        end else begin
          logic [RW-1:0] e;
          e = expQ.pop_front();
          if (outEnable) begin
            check(e[DW] ? "R3 clamp" : "R2 pass", 32'({overOut, dataOut}), 32'(e));
            lastData = dataOut;
            lastOver = overOut;
          end else begin
            // R9: word taken while disabled; re-checked after re-enable
            lastData = e[DW-1:0];
            lastOver = e[DW];
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 data", 32'(dataOut), 32'd0);
    check("R1 over", 32'(overOut), 32'd0);
    check("R1 valid", 32'(dataValid), 32'd0);
    rstN = 1'b1;
    monOn = 1'b1;
    @(negedge clk);
    check("R1 valid after release", 32'(dataValid), 32'd0);

    // R4 first accepted section must be 0: section 3 first is ignored
    send(3, 11'd77, 0);
    check("R5 ignored valid", 32'(dataValid), 32'd0);
    check("R5 ignored data", 32'(dataOut), 32'd0);

    // R2/R3/R4 one full round with boundaries
    send(0, 11'd0, 1);
    send(1, 11'd1023, 1);
    send(2, 11'd1024, 1);
    check("R7 hold data", 32'(dataOut), 32'h3FF);
    check("R7 hold over", 32'(overOut), 32'd1);
    send(3, 11'd2047, 1);
    send(4, 11'd512, 1);
    // R5 out-of-turn strobe from section 7 while 5 is expected
    send(7, 11'd5, 0);
    check("R5 ignored valid", 32'(dataValid), 32'd0);
    check("R5 ignored data", 32'(dataOut), 32'd512);
    send(5, 11'd1, 1);
    send(6, 11'd300, 1);
    send(7, 11'd1500, 1);
    // R4 wrap back to section 0
    send(0, 11'd12, 2);
    check("R4 wrap to 0", 32'(dataOut), 32'd12);

    // R6 alternate-cycle cadence: valid toggles each clock
    fork
      begin
        for (int k = 0; k < NS; k++) send((1 + k) % NS, RW'($urandom_range(0, 2047)), 0);
      end
      begin
        @(negedge clk); @(negedge clk);
        for (int c = 0; c < 6; c++) begin
          check("R6 toggle", 32'(dataValid), 32'((c % 2 == 0) ? 1 : 0));
          @(negedge clk);
        end
      end
    join
    repeat (2) @(negedge clk);

    // R8 tri-state
    enN = 1'b1;
    #1;
    check("R8 data hiz", 32'(dataOut === 10'bz), 32'd1);
    check("R8 over hiz", 32'(overOut === 1'bz), 32'd1);
    check("R8 flag low", 32'(outEnable), 32'd0);
    // R9 word accepted while disabled
    send(1, 11'd345, 1);
    check("R8 valid driven", 32'(dataValid === 1'b0), 32'd1);
    enN = 1'b0;
    #1;
    check("R8 flag high", 32'(outEnable), 32'd1);
    check("R9 data kept", 32'(dataOut), 32'd345);
    check("R9 over kept", 32'(overOut), 32'd0);

    // random stream
    for (int n = 0; n < 40; n++) send(expPtr, RW'($urandom_range(0, 2047)), n % 2);
    repeat (3) @(negedge clk);
    check("R7 final hold", 32'({overOut, dataOut}), 32'({lastOver, lastData}));
    check("R2 queue drained", 32'(expQ.size()), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule